// File: doc/BRIEF.md
# Floating-point CSR access gate

This block holds the floating-point control and status state of a hart: a 5-bit accrued-exception field and a 3-bit rounding-mode field. It exposes three CSR views of that state: a flags view, a rounding-mode view and a composite view that packs both. The CSR file of the core routes an access here whenever the address matches one of the three views. The block answers in the same cycle with read data or a trap, and commits a write on the next clock edge if no trap is raised.

Every access is screened before it may read or change the state. The floating-point extension must be present and the floating-point status must not be Off. When both the state-enable extension and the in-integer-register floating-point extension are configured, three state-enable bits are also consulted. The machine bit is checked first, then the hypervisor bit, then the supervisor bit. Only the first failing check picks the trap: an illegal-instruction trap or a virtual-instruction trap, depending on the check and on the virtualization mode. The same rules apply to all three views.

Top module: `fp_csr_gate`

## Requirements
- R1: After reset both the flags field and the rounding-mode field are zero.
- R2: An access to any of the three views raises an illegal-instruction trap when the floating-point extension is disabled or the floating-point status is Off.
- R3: State-enable checks apply only when both the state-enable extension and the in-integer-register floating-point extension are enabled; otherwise no state-enable bit can cause a trap.
- R4: With gating active, privilege below machine (encoding 0 user, 1 supervisor, 3 machine) and the machine enable bit clear raise an illegal-instruction trap. This check takes priority over the hypervisor and supervisor checks.
- R5: With gating active and the machine check passed, virtualized mode with the hypervisor enable bit clear raises a virtual-instruction trap.
- R6: With gating active and the earlier checks passed, supervisor mode present, privilege user and the supervisor enable bit clear raise a trap. The trap is virtual-instruction when virtualized and illegal-instruction otherwise.
- R7: An access that traps returns zero read data and leaves both fields unchanged.
- R8: The composite view at address 0x003 reads as {zeros, rounding mode in bits 7:5, flags in bits 4:0}. A write to it loads flags from bits 4:0 and the rounding mode from bits 7:5.
- R9: The flags view (0x001) and the rounding-mode view (0x002) read zero-extended. Writes to them keep only the low 5 bits and the low 3 bits respectively.
- R10: A request to any other address raises no trap, returns zero and changes nothing.
- R11: Trap outputs and read data are combinational and valid in the cycle of the request; a write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request valid |
| we | input | 1 | Request is a write |
| addr | input | 12 | CSR address |
| wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization mode |
| fs_off | input | 1 | Floating-point status is Off |
| men_fp | input | 1 | Machine state-enable bit for FP CSRs |
| hen_fp | input | 1 | Hypervisor state-enable bit for FP CSRs |
| sen_fp | input | 1 | Supervisor state-enable bit for FP CSRs |
| cfg_f | input | 1 | Floating-point extension enabled |
| cfg_stateen | input | 1 | State-enable extension enabled |
| cfg_finx | input | 1 | In-integer-register FP extension enabled |
| cfg_s | input | 1 | Supervisor mode implemented |
| rdata | output | XLEN | Read data |
| illegal_trap | output | 1 | Illegal-instruction trap |
| virtual_trap | output | 1 | Virtual-instruction trap |
| fflags_q | output | 5 | Current accrued-exception field |
| frm_q | output | 3 | Current rounding-mode field |

## Verification
The bench sets up cases where several state-enable bits are clear at once. A design that checked them in the wrong order would give a virtual-instruction trap where the machine check demands an illegal-instruction trap. It probes the supervisor check in both virtualization modes. It also probes it with supervisor mode absent, where a design that ignored that flag would trap user-mode accesses that must pass. It writes wide values through all three views, so a missing mask or a shifted composite slice shows up as wrong read data. It follows each trapped write with a permitted read, so a design that commits writes despite a trap is caught.

// File: rtl/fp_csr_gate.sv
module fp_csr_gate #(
  parameter int XLEN      = 32,
  parameter int FLAGS_W   = 5,
  parameter int RM_W      = 3,
  parameter logic [11:0] A_FLAGS = 12'h001,
  parameter logic [11:0] A_RM    = 12'h002,
  parameter logic [11:0] A_ALL   = 12'h003
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            we,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            fs_off,
  input  logic            men_fp,
  input  logic            hen_fp,
  input  logic            sen_fp,
  input  logic            cfg_f,
  input  logic            cfg_stateen,
  input  logic            cfg_finx,
  input  logic            cfg_s,
  output logic [XLEN-1:0] rdata,
  output logic            illegal_trap,
  output logic            virtual_trap,
  output logic [FLAGS_W-1:0] fflags_q,
  output logic [RM_W-1:0]    frm_q
);
  localparam int RM_LSB = FLAGS_W;
  localparam int ALL_W  = FLAGS_W + RM_W;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_M = 2'd3;

  logic hit_flags, hit_rm, hit_all, hit;
  logic gate_on, base_bad, m_bad, h_bad, s_bad;
  logic trap, commit;

  assign hit_flags = addr == A_FLAGS;
  assign hit_rm    = addr == A_RM;
  assign hit_all   = addr == A_ALL;
  assign hit       = req && (hit_flags || hit_rm || hit_all);

  assign gate_on  = cfg_stateen && cfg_finx;
  assign base_bad = !cfg_f || fs_off;
  assign m_bad    = gate_on && (priv != PRV_M) && !men_fp;
  assign h_bad    = gate_on && virt && !hen_fp;
  assign s_bad    = gate_on && cfg_s && (priv == PRV_U) && !sen_fp;

  always_comb begin
    illegal_trap = 1'b0;
    virtual_trap = 1'b0;
    if (hit) begin
      if (base_bad || m_bad)  illegal_trap = 1'b1;
      else if (h_bad)         virtual_trap = 1'b1;
      else if (s_bad) begin
        if (virt) virtual_trap = 1'b1;
        else      illegal_trap = 1'b1;
      end
    end
  end

  assign trap   = illegal_trap || virtual_trap;
  assign commit = hit && we && !trap;

  always_comb begin
    rdata = '0;
    if (hit && !trap) begin
      if (hit_flags)   rdata[FLAGS_W-1:0] = fflags_q;
      else if (hit_rm) rdata[RM_W-1:0]    = frm_q;
      else             rdata[ALL_W-1:0]   = {frm_q, fflags_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fflags_q <= '0;
      frm_q    <= '0;
    end else if (commit) begin
      if (hit_flags || hit_all) fflags_q <= wdata[FLAGS_W-1:0];
      if (hit_rm)               frm_q    <= wdata[RM_W-1:0];
      else if (hit_all)         frm_q    <= wdata[RM_LSB +: RM_W];
    end
  end
endmodule

module fp_csr_gate_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            we,
  input logic [11:0]     addr,
  input logic [XLEN-1:0] wdata,
  input logic [1:0]      priv,
  input logic            virt,
  input logic            cfg_f,
  input logic            cfg_stateen,
  input logic            cfg_finx,
  input logic [XLEN-1:0] rdata,
  input logic            illegal_trap,
  input logic            virtual_trap,
  input logic [4:0]      fflags_q,
  input logic [2:0]      frm_q
);
  logic fp_addr;
  assign fp_addr = addr == 12'h001 || addr == 12'h002 || addr == 12'h003;

  // R2
  fdis_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fp_addr && !cfg_f) |-> illegal_trap);

  // R3
  nogate_novirt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_stateen && cfg_finx) |-> !virtual_trap);

  // R5
  virt_needs_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    virtual_trap |-> (virt && !illegal_trap));

  // R7
  trap_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_trap || virtual_trap) |=> ($stable(fflags_q) && $stable(frm_q)));

  // R7
  trap_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_trap || virtual_trap) |-> rdata == '0);

  // R9
  flags_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == 12'h001 && !illegal_trap && !virtual_trap)
      |=> fflags_q == $past(wdata[4:0]));

  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fp_addr) |=> ($stable(fflags_q) && $stable(frm_q)));

  // R4
  mach_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd3 && !virt && cfg_f && req) |-> !virtual_trap);
endmodule

bind fp_csr_gate fp_csr_gate_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .priv(priv), .virt(virt), .cfg_f(cfg_f), .cfg_stateen(cfg_stateen),
  .cfg_finx(cfg_finx), .rdata(rdata), .illegal_trap(illegal_trap),
  .virtual_trap(virtual_trap), .fflags_q(fflags_q), .frm_q(frm_q)
);

// File: tb/fp_csr_gate_tb.sv
module fp_csr_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [XLEN-1:0] wdata = '0;
  logic [1:0] priv = 2'd3;
  logic virt = 1'b0, fs_off = 1'b0;
  logic men_fp = 1'b1, hen_fp = 1'b1, sen_fp = 1'b1;
  logic cfg_f = 1'b1, cfg_stateen = 1'b1, cfg_finx = 1'b1, cfg_s = 1'b1;
  logic [XLEN-1:0] rdata;
  logic illegal_trap, virtual_trap;
  logic [4:0] fflags_q;
  logic [2:0] frm_q;

  int checks = 0, fails = 0;
  logic [31:0] rd;
  logic il, vi;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_csr_gate #(.XLEN(XLEN)) dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    rd = rdata; il = illegal_trap; vi = virtual_trap;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic defaults();
    priv = 2'd3; virt = 1'b0; fs_off = 1'b0;
    men_fp = 1'b1; hen_fp = 1'b1; sen_fp = 1'b1;
    cfg_f = 1'b1; cfg_stateen = 1'b1; cfg_finx = 1'b1; cfg_s = 1'b1;
  endtask

  task automatic t_reset();
    acc(12'h003, 1'b0, 0);
    check("R1 fcsr after reset", rd, 0);
    check("R11 no trap on read", {il, vi}, 0);
  endtask

  task automatic t_composite();
    acc(12'h003, 1'b1, 32'hFFFF_FFE5);
    acc(12'h003, 1'b0, 0);
    check("R8 fcsr read", rd, 32'hE5);
    acc(12'h001, 1'b0, 0);
    check("R8 flags slice", rd, 32'h05);
    acc(12'h002, 1'b0, 0);
    check("R8 rm slice", rd, 32'h7);
  endtask

  task automatic t_masked();
    acc(12'h001, 1'b1, 32'hFFFF_FFFF);
    acc(12'h001, 1'b0, 0);
    check("R9 flags masked", rd, 32'h1F);
    acc(12'h002, 1'b1, 32'h0000_000A);
    acc(12'h003, 1'b0, 0);
    check("R9 rm masked", rd, 32'h5F);
  endtask

  task automatic t_disabled();
    cfg_f = 1'b0;
    acc(12'h001, 1'b1, 0);
    check("R2 F disabled illegal", {il, vi}, 2'b10);
    check("R7 zero read on trap", rd, 0);
    cfg_f = 1'b1; fs_off = 1'b1;
    acc(12'h003, 1'b1, 0);
    check("R2 FS off illegal", {il, vi}, 2'b10);
    fs_off = 1'b0;
    acc(12'h003, 1'b0, 0);
    check("R7 state kept after trap", rd, 32'h5F);
  endtask

  task automatic t_skip();
    cfg_finx = 1'b0; priv = 2'd0; men_fp = 1'b0; hen_fp = 1'b0; sen_fp = 1'b0; virt = 1'b1;
    acc(12'h002, 1'b0, 0);
    check("R3 no gate without finx", {il, vi}, 0);
    cfg_finx = 1'b1; cfg_stateen = 1'b0;
    acc(12'h002, 1'b0, 0);
    check("R3 no gate without stateen", {il, vi}, 0);
    defaults();
  endtask

  task automatic t_machine();
    priv = 2'd1; virt = 1'b1; men_fp = 1'b0; hen_fp = 1'b0;
    acc(12'h001, 1'b1, 32'h3);
    check("R4 machine first illegal", {il, vi}, 2'b10);
    priv = 2'd3; virt = 1'b0;
    acc(12'h001, 1'b0, 0);
    check("R4 M mode passes", {il, vi}, 0);
    check("R7 trapped write ignored", rd, 32'h1F);
    defaults();
  endtask

  task automatic t_hyp();
    priv = 2'd1; virt = 1'b1; hen_fp = 1'b0; sen_fp = 1'b0;
    acc(12'h003, 1'b1, 0);
    check("R5 hypervisor virtual", {il, vi}, 2'b01);
    virt = 1'b0;
    acc(12'h003, 1'b0, 0);
    check("R5 not virtualized passes", {il, vi}, 0);
    check("R7 state after virtual trap", rd, 32'h5F);
    defaults();
  endtask

  task automatic t_sup();
    priv = 2'd0; sen_fp = 1'b0; virt = 1'b1;
    acc(12'h001, 1'b0, 0);
    check("R6 user virt virtual", {il, vi}, 2'b01);
    virt = 1'b0;
    acc(12'h001, 1'b0, 0);
    check("R6 user illegal", {il, vi}, 2'b10);
    cfg_s = 1'b0;
    acc(12'h001, 1'b0, 0);
    check("R6 no S mode passes", {il, vi}, 0);
    cfg_s = 1'b1; priv = 2'd1;
    acc(12'h001, 1'b0, 0);
    check("R6 S mode passes", {il, vi}, 0);
    defaults();
  endtask

  task automatic t_other();
    acc(12'h300, 1'b1, 32'hFFFF_FFFF);
    check("R10 no trap", {il, vi}, 0);
    check("R10 zero read", rd, 0);
    acc(12'h003, 1'b0, 0);
    check("R10 state unchanged", rd, 32'h5F);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fflags reset", {27'd0, fflags_q}, 0);
    check("R1 frm reset", {29'd0, frm_q}, 0);
    rst_n = 1'b1;
    t_reset();
    t_composite();
    t_masked();
    t_disabled();
    t_skip();
    t_machine();
    t_hyp();
    t_sup();
    t_other();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule